// File: doc/BRIEF.md
# Scatter-Gather Receive Descriptor Filler

This block is the stream-to-memory half of a DMA channel. It takes one incoming byte frame, together with five application words that travel with it. It spreads the frame's bytes over the buffers named by a linked chain of descriptors in memory. After it has used a descriptor, it rewrites that descriptor's status word with flags. On the descriptor that took the frame's final byte, it also stores the application words. A separate register block owns the channel's run and idle bits and the current-descriptor and tail-descriptor pointers. This block reads those four values. It returns a strobe to load a new current pointer, a strobe to set idle, and a one-cycle frame-completion pulse.

The incoming frame uses a valid/ready handshake, one byte per beat, with a last marker on the final byte. A byte moves only in a cycle where both valid and ready are high. The sender must hold the byte, the last marker and the application words stable while it waits. Ready is low while the engine is idle and waiting for a frame to start, and while it reads or writes descriptor words. Ready is high while bytes are being placed in a buffer. It is also high while an unwanted frame, or the unwanted rest of a frame, is being discarded.

The memory side is a simple single-port master. A read returns its data one cycle after the request. A write takes effect in the cycle it is issued and uses per-byte enables.

Top module: `rxsg_fill`

## Requirements
- R1: When a frame begins while run is 0 or idle is 1, every byte of that frame is accepted and discarded. In that case the block makes no memory access, sends no completion pulse and does not move the current pointer.
- R2: A descriptor occupies 32-bit words at these byte offsets: +0 next pointer, +4 buffer address, +8 control (length in bits 22:0), +12 status, and +16 to +32 for application words 0 to 4. Before using a descriptor, the block reads its first four words. Read data arrives one cycle after the request.
- R3: A descriptor receives the smaller of its length and the number of frame bytes still to come. Those bytes go to consecutive addresses starting at the buffer address. Each byte is written as its own write, with exactly one byte enable set, on lane address[1:0]. A descriptor with length 0 receives no bytes but is still counted as used.
- R4: Every descriptor the block uses gets its fetched status written back with these bits added: bit 31 (complete), always; bit 27 (start of frame), only on the first descriptor of the frame; bit 26 (end of frame), only on the descriptor that received the last byte.
- R5: On the descriptor that received the last byte, the block writes application words 0 to 4, as they were when the last byte was accepted, to offsets +16 to +32. It also raises the frame-completion pulse for exactly one cycle.
- R6: If a fetched descriptor already has status bit 31 set, the block pulses idle-set, writes nothing and discards the rest of the frame. No completion pulse is given for that frame.
- R7: After each used descriptor, the block pulses the current-pointer load with that descriptor's next pointer.
- R8: If the descriptor just finished is the tail descriptor, the block pulses idle-set and stops filling. Any frame bytes still to come are discarded.
- R9: Ready is low during every descriptor read and write, and while the block waits for a frame to start.
- R10: After reset, ready, memory enable and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Channel run bit from the register block |
| idle_i | input | 1 | Channel idle bit from the register block |
| cur_desc_i | input | AW | Current descriptor address |
| tail_desc_i | input | AW | Tail descriptor address |
| cur_desc_wr_o | output | 1 | Load strobe for the current pointer |
| cur_desc_o | output | AW | New current pointer value |
| idle_set_o | output | 1 | Strobe that sets the idle bit |
| frame_done_o | output | 1 | One-cycle pulse when a frame is complete |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Stream byte ready |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Marks the final byte of the frame |
| s_app_i | input | NAPP*32 | Application words; word k is in bits 32k+31:32k |
| mem_en_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the read |

## Verification
The hardest cases to reach are the ones where filling stops before the frame ends: the tail is reached with bytes still to come, or the engine meets a descriptor already marked complete. In both cases the engine must swallow the rest of the frame without a completion pulse and still be ready for the next frame. The stimulus table gets there by choosing the tail index and the buffer lengths relative to the frame length. Each table row is followed by a fresh frame, so a stuck engine is exposed. Directed tests also pre-mark the first descriptor as complete, and send frames while the channel is stopped or idle.

// File: rtl/rxsg_pkg.sv
package rxsg_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LANES     = WORD_W / 8;
  localparam int unsigned LANE_BITS = $clog2(LANES);
  localparam int unsigned HDR_WORDS = 4;
  localparam int unsigned IDX_NEXT  = 0;
  localparam int unsigned IDX_BUF   = 1;
  localparam int unsigned IDX_CTRL  = 2;
  localparam int unsigned IDX_STAT  = 3;
  localparam int unsigned IDX_APP   = 4;
  localparam int unsigned BIT_EOF   = 26;
  localparam int unsigned BIT_SOF   = 27;
  localparam int unsigned BIT_DONE  = 31;

  typedef enum logic [3:0] {
    ST_WAIT, ST_RD_ISSUE, ST_RD_TAKE, ST_CHECK, ST_FILL,
    ST_APP, ST_STAT, ST_ADV, ST_DRAIN
  } fill_state_e;

  typedef enum logic [1:0] {MC_NONE, MC_READ, MC_BYTE, MC_WORD} mem_cmd_e;
endpackage

// File: rtl/rxsg_desc_regs.sv
module rxsg_desc_regs
  import rxsg_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [1:0]        idx_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [AW-1:0]     next_o,
  output logic [AW-1:0]     buf_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [WORD_W-1:0] stat_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_o <= '0;
      buf_o  <= '0;
      len_o  <= '0;
      stat_o <= '0;
    end else if (cap_i) begin
      case (idx_i)
        2'(IDX_NEXT): next_o <= word_i[AW-1:0];
        2'(IDX_BUF):  buf_o  <= word_i[AW-1:0];
        2'(IDX_CTRL): len_o  <= word_i[LEN_W-1:0];
        default:      stat_o <= word_i;
      endcase
    end
  end
endmodule

// File: rtl/rxsg_mem_req.sv
module rxsg_mem_req
  import rxsg_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mem_cmd_e          cmd_i,
  input  logic [AW-1:0]     base_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [7:0]        byte_i,
  output logic              en_o,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [LANES-1:0]  be_o,
  output logic [WORD_W-1:0] wdata_o
);
  assign en_o   = (cmd_i != MC_NONE);
  assign we_o   = (cmd_i == MC_BYTE) || (cmd_i == MC_WORD);
  assign addr_o = {base_i[AW-1:LANE_BITS], {LANE_BITS{1'b0}}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be_o[l] = (cmd_i == MC_WORD) ||
                     ((cmd_i == MC_BYTE) && (base_i[LANE_BITS-1:0] == LANE_BITS'(l)));
    assign wdata_o[8*l +: 8] = (cmd_i == MC_BYTE) ? byte_i : word_i[8*l +: 8];
  end

  // R3: a byte store touches exactly one lane
  p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && we_o && cmd_i == MC_BYTE) |-> ($countones(be_o) == 1));
endmodule

// File: rtl/rxsg_fill.sv
module rxsg_fill
  import rxsg_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 23,
  parameter int unsigned NAPP  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_i,
  input  logic                   idle_i,
  input  logic [AW-1:0]          cur_desc_i,
  input  logic [AW-1:0]          tail_desc_i,
  output logic                   cur_desc_wr_o,
  output logic [AW-1:0]          cur_desc_o,
  output logic                   idle_set_o,
  output logic                   frame_done_o,
  input  logic                   s_valid_i,
  output logic                   s_ready_o,
  input  logic [7:0]             s_data_i,
  input  logic                   s_last_i,
  input  logic [NAPP*WORD_W-1:0] s_app_i,
  output logic                   mem_en_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [LANES-1:0]       mem_be_o,
  output logic [WORD_W-1:0]      mem_wdata_o,
  input  logic [WORD_W-1:0]      mem_rdata_i
);
  localparam int unsigned IDX_W = (NAPP > HDR_WORDS) ? $clog2(NAPP) : 2;

  fill_state_e             state_q;
  logic [AW-1:0]           cur_q;
  logic [IDX_W-1:0]        widx_q;
  logic [LEN_W-1:0]        pos_q;
  logic                    sof_q, eof_q;
  logic [NAPP*WORD_W-1:0]  app_q;

  logic [AW-1:0]     d_next, d_buf;
  logic [LEN_W-1:0]  d_len;
  logic [WORD_W-1:0] d_stat;
  logic              cap;
  mem_cmd_e          cmd;
  logic [AW-1:0]     req_base;
  logic [WORD_W-1:0] req_word;
  logic              at_tail;

  assign at_tail    = (cur_q == tail_desc_i);
  assign cur_desc_o = d_next;

  rxsg_desc_regs #(.AW(AW), .LEN_W(LEN_W)) u_desc (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .idx_i(widx_q[1:0]),
    .word_i(mem_rdata_i), .next_o(d_next), .buf_o(d_buf),
    .len_o(d_len), .stat_o(d_stat)
  );

  rxsg_mem_req #(.AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .base_i(req_base),
    .word_i(req_word), .byte_i(s_data_i), .en_o(mem_en_o),
    .we_o(mem_we_o), .addr_o(mem_addr_o), .be_o(mem_be_o),
    .wdata_o(mem_wdata_o)
  );

  always_comb begin
    cmd           = MC_NONE;
    req_base      = '0;
    req_word      = '0;
    cap           = 1'b0;
    s_ready_o     = 1'b0;
    cur_desc_wr_o = 1'b0;
    idle_set_o    = 1'b0;
    frame_done_o  = 1'b0;
    case (state_q)
      ST_RD_ISSUE: begin
        cmd      = MC_READ;
        req_base = cur_q + (AW'(widx_q) << 2);
      end
      ST_RD_TAKE: cap = 1'b1;
      ST_CHECK:   idle_set_o = d_stat[BIT_DONE];
      ST_FILL: begin
        s_ready_o = 1'b1;
        if (s_valid_i) begin
          cmd      = MC_BYTE;
          req_base = d_buf + AW'(pos_q);
        end
      end
      ST_APP: begin
        cmd      = MC_WORD;
        req_base = cur_q + AW'(IDX_APP * 4) + (AW'(widx_q) << 2);
        req_word = app_q[int'(widx_q)*WORD_W +: WORD_W];
      end
      ST_STAT: begin
        cmd      = MC_WORD;
        req_base = cur_q + AW'(IDX_STAT * 4);
        req_word = d_stat;
        req_word[BIT_DONE] = 1'b1;
        if (sof_q) req_word[BIT_SOF] = 1'b1;
        if (eof_q) req_word[BIT_EOF] = 1'b1;
      end
      ST_ADV: begin
        cur_desc_wr_o = 1'b1;
        frame_done_o  = eof_q;
        idle_set_o    = at_tail;
      end
      ST_DRAIN: s_ready_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      cur_q   <= '0;
      widx_q  <= '0;
      pos_q   <= '0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
      app_q   <= '0;
    end else begin
      case (state_q)
        ST_WAIT: if (s_valid_i) begin
          if (run_i && !idle_i) begin
            cur_q   <= cur_desc_i;
            sof_q   <= 1'b1;
            widx_q  <= '0;
            state_q <= ST_RD_ISSUE;
          end else begin
            state_q <= ST_DRAIN;
          end
        end
        ST_RD_ISSUE: state_q <= ST_RD_TAKE;
        ST_RD_TAKE: begin
          if (widx_q == IDX_W'(HDR_WORDS - 1)) state_q <= ST_CHECK;
          else begin
            widx_q  <= widx_q + 1'b1;
            state_q <= ST_RD_ISSUE;
          end
        end
        ST_CHECK: begin
          pos_q <= '0;
          eof_q <= 1'b0;
          if (d_stat[BIT_DONE])  state_q <= ST_DRAIN;
          else if (d_len == '0)  state_q <= ST_STAT;
          else                   state_q <= ST_FILL;
        end
        ST_FILL: if (s_valid_i) begin
          pos_q <= pos_q + 1'b1;
          if (s_last_i) begin
            eof_q   <= 1'b1;
            app_q   <= s_app_i;
            widx_q  <= '0;
            state_q <= ST_APP;
          end else if (pos_q + LEN_W'(1) == d_len) begin
            state_q <= ST_STAT;
          end
        end
        ST_APP: begin
          if (widx_q == IDX_W'(NAPP - 1)) state_q <= ST_STAT;
          else widx_q <= widx_q + 1'b1;
        end
        ST_STAT: state_q <= ST_ADV;
        ST_ADV: begin
          cur_q  <= d_next;
          sof_q  <= 1'b0;
          widx_q <= '0;
          if (eof_q)        state_q <= ST_WAIT;
          else if (at_tail) state_q <= ST_DRAIN;
          else              state_q <= ST_RD_ISSUE;
        end
        ST_DRAIN: if (s_valid_i && s_last_i) state_q <= ST_WAIT;
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  // R1: a discarded frame never reaches memory
  p_drop_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> !mem_en_o);
  // R3: bytes stay inside the descriptor's buffer
  p_byte_in_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && mem_we_o && state_q == ST_FILL) |-> (pos_q < d_len));
  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);
  // R7: the engine follows the pointer it hands out
  p_cur_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_desc_wr_o |=> (cur_q == $past(cur_desc_o)));
  // R9: no byte is taken while a descriptor word is read
  p_no_ready_on_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !mem_we_o) |-> !s_ready_o);
endmodule

// File: tb/test_rxsg_fill.sv
module test_rxsg_fill;
  localparam int AW = 32;
  localparam int NAPP = 5;
  // rows: frame length, len0, len1, len2, tail index, seed
  localparam int CASES [6][6] = '{
    '{20, 8, 8, 8, 2, 3},
    '{ 8, 8, 8, 8, 2, 5},
    '{30, 8, 8, 8, 1, 7},
    '{ 5,16, 8, 8, 2, 9},
    '{12, 0,12, 8, 2,11},
    '{24, 8, 8, 8, 0,13}
  };

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic run_r = 0, idle_r = 0;
  logic [AW-1:0] cur_r = 0, tail_r = 0;
  logic cur_wr, idle_set, done;
  logic [AW-1:0] cur_o;
  logic s_valid = 0, s_ready, s_last = 0;
  logic [7:0] s_data = 0;
  logic [NAPP*32-1:0] s_app = '0;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem [256];

  int n_chk = 0, n_fail = 0, n_done = 0, n_idle = 0, n_wr = 0, n_viol = 0;

  rxsg_fill i_rxsg_fill (
    .clk(clk), .rst_n(rst_n), .run_i(run_r), .idle_i(idle_r),
    .cur_desc_i(cur_r), .tail_desc_i(tail_r), .cur_desc_wr_o(cur_wr),
    .cur_desc_o(cur_o), .idle_set_o(idle_set), .frame_done_o(done),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .s_last_i(s_last), .s_app_i(s_app), .mem_en_o(mem_en),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_en && mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) mem[mem_addr[9:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
  end

  always @(negedge clk) if (rst_n) begin
    if (done) n_done++;
    if (idle_set) begin n_idle++; idle_r = 1; end
    if (cur_wr) cur_r = cur_o;
    if (mem_en && mem_we) n_wr++;
    if (mem_en && !mem_we && s_ready) n_viol++;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(int a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  task automatic setup(int l0, int l1, int l2, int tl, bit pre_done);
    int lens [3];
    lens = '{l0, l1, l2};
    for (int w = 0; w < 256; w++) mem[w] = 32'hEEEEEEEE;
    for (int i = 0; i < 4; i++) begin
      mem[i*16+0] = 32'((i+1)*64);
      mem[i*16+1] = (i < 3) ? 32'(256*(i+1)) : 32'h0;
      mem[i*16+2] = (i < 3) ? 32'(lens[i]) : 32'd8;
      mem[i*16+3] = (i == 3 || (i == 0 && pre_done)) ? 32'h8000_0000 : 32'h0;
      for (int k = 4; k < 9; k++) mem[i*16+k] = 0;
    end
    cur_r = 0; tail_r = 32'(tl*64); idle_r = 0; run_r = 1;
    n_done = 0; n_idle = 0; n_wr = 0;
  endtask

  task automatic send_frame(int n, int seed);
    for (int k = 0; k < NAPP; k++) s_app[k*32 +: 32] = 32'(seed*256 + k + 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1; s_data = 8'(seed + k); s_last = (k == n-1);
      while (!s_ready) @(negedge clk);
    end
    @(negedge clk); s_valid = 0; s_last = 0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!s_ready && !mem_en && !done && !idle_set && !cur_wr, "R10",
          "outputs in reset", {s_ready, mem_en, done, idle_set, cur_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!s_ready && !mem_en, "R10", "after reset release", {s_ready, mem_en}, 0);

    for (int r = 0; r < 6; r++) begin
      int flen, tl, seed, rem, last, off;
      int lens [3]; int cnt [3]; bit used [3]; bit eofd [3];
      bit ok;
      flen = CASES[r][0]; lens = '{CASES[r][1], CASES[r][2], CASES[r][3]};
      tl = CASES[r][4]; seed = CASES[r][5];
      setup(lens[0], lens[1], lens[2], tl, 0);
      send_frame(flen, seed);
      rem = flen; last = 0;
      for (int i = 0; i < 3; i++) begin cnt[i] = 0; used[i] = 0; eofd[i] = 0; end
      for (int i = 0; i < 3; i++) begin
        used[i] = 1; cnt[i] = (lens[i] < rem) ? lens[i] : rem; rem -= cnt[i]; last = i;
        if (rem == 0) begin eofd[i] = 1; break; end
        if (i == tl) break;
      end
      off = 0;
      for (int i = 0; i < 3; i++) begin
        logic [31:0] es;
        es = used[i] ? (32'h8000_0000 | (i == 0 ? 32'h0800_0000 : 0) |
                        (eofd[i] ? 32'h0400_0000 : 0)) : 32'h0;
        // R4 status flags
        check(mem[i*16+3] == es, "R4", $sformatf("row %0d desc %0d status", r, i),
              mem[i*16+3], es);
        // R3 clamped byte placement
        ok = 1;
        for (int k = 0; k < cnt[i]; k++)
          if (mbyte(256*(i+1)+k) != 8'(seed + off + k)) ok = 0;
        if (mbyte(256*(i+1)+cnt[i]) != 8'hEE) ok = 0;
        check(ok, "R3", $sformatf("row %0d desc %0d bytes (count %0d)", r, i, cnt[i]),
              ok, 1);
        off += cnt[i];
        // R5 application words on last descriptor only
        ok = 1;
        for (int k = 0; k < NAPP; k++)
          if (mem[i*16+4+k] != (eofd[i] ? 32'(seed*256 + k + 1) : 32'h0)) ok = 0;
        check(ok, "R5", $sformatf("row %0d desc %0d app words", r, i), ok, 1);
      end
      check(n_done == (eofd[last] ? 1 : 0), "R5", $sformatf("row %0d done pulses", r),
            n_done, eofd[last]);
      check(n_idle == (last == tl ? 1 : 0), "R8", $sformatf("row %0d idle-set", r),
            n_idle, last == tl);
      check(cur_r == 32'((last+1)*64), "R7", $sformatf("row %0d current pointer", r),
            cur_r, (last+1)*64);
    end

    // R1 stopped channel
    setup(8, 8, 8, 2, 0); run_r = 0;
    send_frame(6, 21);
    check(n_wr == 0 && n_done == 0 && cur_r == 0, "R1", "run=0 frame ignored",
          n_wr, 0);
    // R1 idle channel
    setup(8, 8, 8, 2, 0); idle_r = 1;
    send_frame(6, 22);
    check(n_wr == 0 && n_done == 0 && mem[3] == 0, "R1", "idle=1 frame ignored",
          n_wr, 0);
    // R6 descriptor already complete
    setup(8, 8, 8, 2, 1);
    send_frame(10, 23);
    check(n_idle == 1 && n_wr == 0 && n_done == 0 && cur_r == 0, "R6",
          "complete descriptor abandons frame", {n_idle, n_wr, n_done}, 32'h1_0_0);
    // R2 engine still usable afterwards, fetch from chain start
    setup(4, 8, 8, 2, 0);
    send_frame(3, 24);
    check(mem[3] == 32'h8C00_0000 && n_done == 1, "R2", "fetch after abandon",
          mem[3], 32'h8C00_0000);
    // R9 ready never high during a descriptor read
    check(n_viol == 0, "R9", "ready during fetch", n_viol, 0);
    report();
  end
endmodule